// File: doc/BRIEF.md
# Security-Aware Cache Policy Override Register

This block is a single coprocessor-style control register with six override bits. Three of the bits govern regions marked secure and three govern regions marked non-secure. For each group, one bit suppresses data linefill, one bit suppresses instruction linefill, and one bit forces write-through on write-back regions. Software reaches the register through a transfer port. Each transfer carries the coprocessor selector fields, a direction, the issuing world and the privilege level. The block answers with read data or with an undefined-instruction indication.

A second path is purely combinational and sits beside the cache lookup. It takes the security attribute, cacheability, write-back marking and instruction/data type of each memory access. From these it produces two flags: the effective force-write-through flag and the linefill-enable flag. The cache controller consumes both flags in the same cycle. Secure software uses the register to stop the cache from filling or holding dirty lines while maintenance is in progress.

Top module: `cache_ovr_reg`

## Requirements
- R1: A transfer addresses the register only when opcode1 = 0, primary number = 9, secondary number = 8 and opcode2 = 0. Any other transfer returns zero read data, raises no undefined indication and leaves the register unchanged.
- R2: After reset all six bits are 0. Linefill is therefore enabled for every cacheable access, and write-through is never forced.
- R3: A secure privileged transfer reads and writes all of bits 5:0. Bits 31:6 always read as zero, and their write values are discarded.
- R4: A non-secure privileged transfer reads and writes bits 2:0 normally. It reads bits 5:3 as zero, and its writes to bits 5:3 leave them unchanged.
- R5: A user-mode transfer to the register, read or write, from either world, raises the undefined indication in the same cycle. It returns zero read data and changes no bit.
- R6: The linefill-enable flag is 1 only for a cacheable access whose disable bit is 0. The disable bit comes from the secure group (bits 5:3) when the access is secure and from the non-secure group (bits 2:0) otherwise. Within a group, the group's lowest bit (bit 3 or bit 0) is the data disable bit and the next bit (bit 4 or bit 1) is the instruction disable bit.
- R7: The force-write-through flag is 1 only for an access that is both cacheable and write-back, and whose group write-through bit is 1. That bit is bit 5 for a secure access and bit 2 otherwise. The flag does not depend on the instruction/data type.
- R8: A write changes the policy flags from the cycle after it is accepted. Read data and the flags in the cycle of the write reflect the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| acc_valid_i | input | 1 | A register transfer is presented this cycle |
| acc_write_i | input | 1 | 1 = write to the register, 0 = read |
| acc_secure_i | input | 1 | The transfer comes from the secure world |
| acc_priv_i | input | 1 | The transfer comes from a privileged mode |
| acc_op1_i | input | 3 | Opcode1 selector field |
| acc_crn_i | input | 4 | Primary register number |
| acc_crm_i | input | 4 | Secondary register number |
| acc_op2_i | input | 3 | Opcode2 selector field |
| acc_wdata_i | input | 32 | Write data from the core register |
| acc_rdata_o | output | 32 | Read data to the core register |
| acc_undef_o | output | 1 | Undefined-instruction indication |
| mem_secure_i | input | 1 | The memory access targets a secure region |
| mem_cacheable_i | input | 1 | The region is cacheable |
| mem_writeback_i | input | 1 | The region is marked write-back |
| mem_instr_i | input | 1 | 1 = instruction fetch, 0 = data access |
| mem_force_wt_o | output | 1 | Treat this access as write-through |
| mem_linefill_en_o | output | 1 | A miss on this access may allocate a line |

## Verification
A register write and a memory access that consults the same group of bits can occur in the same cycle. The bench provokes this by attaching memory attributes to every transfer step, including the sweep of writes. Every one of the 64 override values is written with a policy-relevant access in the same cycle and is then followed by accesses in the next cycles. The reference model judges the write cycle against the old contents and the following cycles against the new contents. Any early forwarding or late update of the register therefore shows up as a mismatch on the flags.

// File: rtl/cor_pkg.sv
package cor_pkg;
  localparam int GRP_W  = 3;
  localparam int OVR_W  = 2 * GRP_W;
  localparam int BIT_DL = 0;
  localparam int BIT_IL = 1;
  localparam int BIT_WT = 2;

  typedef logic [OVR_W-1:0] ovr_t;
  typedef logic [GRP_W-1:0] grp_t;

  typedef struct packed {
    logic secure;
    logic cacheable;
    logic writeback;
    logic instr;
  } mem_attr_t;

  // Bits a privileged transfer from the given world may see and change.
  function automatic ovr_t world_mask(input logic secure);
    ovr_t m;
    m = '0;
    m[GRP_W-1:0] = '1;
    if (secure) m[OVR_W-1:GRP_W] = '1;
    return m;
  endfunction

  function automatic grp_t group_of(input ovr_t v, input logic secure);
    return secure ? v[OVR_W-1:GRP_W] : v[GRP_W-1:0];
  endfunction

  function automatic ovr_t merge_bits(input ovr_t old_v, input ovr_t new_v, input ovr_t mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/cor_decode.sv
module cor_decode #(
  parameter int OP1_W = 3,
  parameter int CR_W  = 4,
  parameter int OP2_W = 3,
  parameter int SEL_OP1 = 0,
  parameter int SEL_CRN = 9,
  parameter int SEL_CRM = 8,
  parameter int SEL_OP2 = 0
) (
  input  logic             valid_i,
  input  logic             write_i,
  input  logic             secure_i,
  input  logic             priv_i,
  input  logic [OP1_W-1:0] op1_i,
  input  logic [CR_W-1:0]  crn_i,
  input  logic [CR_W-1:0]  crm_i,
  input  logic [OP2_W-1:0] op2_i,
  output logic             hit_o,
  output logic             wr_en_o,
  output logic             rd_en_o,
  output logic             undef_o,
  output cor_pkg::ovr_t    mask_o
);
  localparam logic [OP1_W-1:0] K_OP1 = OP1_W'(SEL_OP1);
  localparam logic [CR_W-1:0]  K_CRN = CR_W'(SEL_CRN);
  localparam logic [CR_W-1:0]  K_CRM = CR_W'(SEL_CRM);
  localparam logic [OP2_W-1:0] K_OP2 = OP2_W'(SEL_OP2);

  logic fields_match;

  always_comb begin
    fields_match = (op1_i == K_OP1) && (crn_i == K_CRN) &&
                   (crm_i == K_CRM) && (op2_i == K_OP2);
    hit_o   = valid_i && fields_match;
    undef_o = hit_o && !priv_i;
    wr_en_o = hit_o && priv_i && write_i;
    rd_en_o = hit_o && priv_i && !write_i;
    mask_o  = cor_pkg::world_mask(secure_i);
  end
endmodule

// File: rtl/cor_store.sv
module cor_store (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  cor_pkg::ovr_t mask_i,
  input  cor_pkg::ovr_t wdata_i,
  output cor_pkg::ovr_t ovr_q
);
  cor_pkg::ovr_t ovr_d;

  always_comb begin
    ovr_d = ovr_q;
    if (wr_en_i) ovr_d = cor_pkg::merge_bits(ovr_q, wdata_i, mask_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) ovr_q <= '0;
    else         ovr_q <= ovr_d;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ovr_q)); // R1
  AST_MASKED_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((ovr_q & ~$past(mask_i)) == ($past(ovr_q) & ~$past(mask_i)))); // R4
endmodule

// File: rtl/cor_policy.sv
module cor_policy (
  input  cor_pkg::ovr_t     ovr_i,
  input  cor_pkg::mem_attr_t attr_i,
  output logic              force_wt_o,
  output logic              linefill_en_o
);
  cor_pkg::grp_t grp;
  logic          fill_off;

  always_comb begin
    grp           = cor_pkg::group_of(ovr_i, attr_i.secure);
    fill_off      = attr_i.instr ? grp[cor_pkg::BIT_IL] : grp[cor_pkg::BIT_DL];
    linefill_en_o = attr_i.cacheable && !fill_off;
    force_wt_o    = attr_i.cacheable && attr_i.writeback && grp[cor_pkg::BIT_WT];
  end
endmodule

// File: rtl/cache_ovr_reg.sv
module cache_ovr_reg #(
  parameter int DATA_W  = 32,
  parameter int OP1_W   = 3,
  parameter int CR_W    = 4,
  parameter int OP2_W   = 3,
  parameter int SEL_OP1 = 0,
  parameter int SEL_CRN = 9,
  parameter int SEL_CRM = 8,
  parameter int SEL_OP2 = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              acc_secure_i,
  input  logic              acc_priv_i,
  input  logic [OP1_W-1:0]  acc_op1_i,
  input  logic [CR_W-1:0]   acc_crn_i,
  input  logic [CR_W-1:0]   acc_crm_i,
  input  logic [OP2_W-1:0]  acc_op2_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              acc_undef_o,
  input  logic              mem_secure_i,
  input  logic              mem_cacheable_i,
  input  logic              mem_writeback_i,
  input  logic              mem_instr_i,
  output logic              mem_force_wt_o,
  output logic              mem_linefill_en_o
);
  localparam int OVR_W = cor_pkg::OVR_W;

  logic               hit, wr_en, rd_en;
  cor_pkg::ovr_t      mask, ovr_q, wr_bits, rd_bits;
  cor_pkg::mem_attr_t attr;

  cor_decode #(
    .OP1_W(OP1_W), .CR_W(CR_W), .OP2_W(OP2_W),
    .SEL_OP1(SEL_OP1), .SEL_CRN(SEL_CRN), .SEL_CRM(SEL_CRM), .SEL_OP2(SEL_OP2)
  ) u_decode (
    .valid_i(acc_valid_i), .write_i(acc_write_i), .secure_i(acc_secure_i),
    .priv_i(acc_priv_i), .op1_i(acc_op1_i), .crn_i(acc_crn_i),
    .crm_i(acc_crm_i), .op2_i(acc_op2_i), .hit_o(hit), .wr_en_o(wr_en),
    .rd_en_o(rd_en), .undef_o(acc_undef_o), .mask_o(mask)
  );

  assign wr_bits = acc_wdata_i[OVR_W-1:0];

  cor_store u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en),
    .mask_i(mask), .wdata_i(wr_bits), .ovr_q(ovr_q)
  );

  always_comb begin
    rd_bits     = ovr_q & mask;
    acc_rdata_o = '0;
    if (rd_en) acc_rdata_o[OVR_W-1:0] = rd_bits;
  end

  assign attr = '{secure: mem_secure_i, cacheable: mem_cacheable_i,
                  writeback: mem_writeback_i, instr: mem_instr_i};

  cor_policy u_policy (
    .ovr_i(ovr_q), .attr_i(attr),
    .force_wt_o(mem_force_wt_o), .linefill_en_o(mem_linefill_en_o)
  );

  AST_UNDEF_USER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_undef_o |-> (acc_valid_i && !acc_priv_i)); // R5
  AST_USER_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_priv_i) |=> $stable(ovr_q)); // R5
  AST_NS_SECURE_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !acc_secure_i) |-> (acc_rdata_o[OVR_W-1:cor_pkg::GRP_W] == '0)); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rdata_o[DATA_W-1:OVR_W] == '0); // R3
  AST_NO_FILL_UNCACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_cacheable_i |-> !mem_linefill_en_o); // R6
  AST_WT_NEEDS_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_force_wt_o |-> (mem_cacheable_i && mem_writeback_i)); // R7
endmodule

// File: tb/cache_ovr_reg_bench.sv
module cache_ovr_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        v, w, s, p, ms, mc, mwb, mi;
  logic [2:0]  op1, op2;
  logic [3:0]  crn, crm;
  logic [31:0] wd, rd;
  logic        undef, fwt, lfe;

  cache_ovr_reg u_cache_ovr_reg (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(v), .acc_write_i(w),
    .acc_secure_i(s), .acc_priv_i(p), .acc_op1_i(op1), .acc_crn_i(crn),
    .acc_crm_i(crm), .acc_op2_i(op2), .acc_wdata_i(wd), .acc_rdata_o(rd),
    .acc_undef_o(undef), .mem_secure_i(ms), .mem_cacheable_i(mc),
    .mem_writeback_i(mwb), .mem_instr_i(mi), .mem_force_wt_o(fwt),
    .mem_linefill_en_o(lfe)
  );

  int total = 0, failed = 0;
  int model = 0;   // reference copy of the six bits
  bit done = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, judge before posedge, then advance the model.
  task automatic step(input bit av, aw, as, ap, input int f1, fn, fm, f2,
                      input logic [31:0] d, input bit xs, xc, xwb, xi, input string req);
    bit sel;
    int grp, e_rd;
    bit e_lf, e_wt;
    @(negedge clk);
    v = av; w = aw; s = as; p = ap;
    op1 = 3'(f1); crn = 4'(fn); crm = 4'(fm); op2 = 3'(f2); wd = d;
    ms = xs; mc = xc; mwb = xwb; mi = xi;
    #2;
    sel  = av && f1 == 0 && fn == 9 && fm == 8 && f2 == 0;
    e_rd = 0;
    if (sel && ap && !aw) e_rd = as ? model : (model % 8);
    check(req, "rdata", rd, e_rd);
    check(req, "undef", undef, sel && !ap);
    grp  = xs ? (model / 8) : (model % 8);
    e_lf = xc && (((grp >> (xi ? 1 : 0)) & 1) == 0);
    e_wt = xc && xwb && (((grp >> 2) & 1) == 1);
    check("R6", "linefill", lfe, e_lf);
    check("R7", "force_wt", fwt, e_wt);
    if (sel && ap && aw) begin
      if (as) model = d % 64;
      else    model = (model / 8) * 8 + (d % 8);
    end
  endtask

  initial begin
    v = 0; w = 0; s = 0; p = 0; op1 = 0; op2 = 0; crn = 0; crm = 0; wd = 0;
    ms = 0; mc = 0; mwb = 0; mi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R2: reset state visible through a secure read and the policy flags
    step(1,0,1,1, 0,9,8,0, 0, 1,1,1,0, "R2");
    step(0,0,0,0, 0,0,0,0, 0, 0,1,1,1, "R2");
    // R3: secure write of all ones, upper bits discarded
    step(1,1,1,1, 0,9,8,0, 32'hFFFF_FFFF, 0,1,1,0, "R3");
    step(1,0,1,1, 0,9,8,0, 0, 1,1,1,0, "R3");
    // R4: non-secure read and write
    step(1,0,0,1, 0,9,8,0, 0, 0,1,1,1, "R4");
    step(1,1,0,1, 0,9,8,0, 32'h0, 1,1,1,1, "R4");
    step(1,0,1,1, 0,9,8,0, 0, 0,1,1,0, "R4");
    step(1,1,0,1, 0,9,8,0, 32'h5, 1,1,0,0, "R4");
    step(1,0,0,1, 0,9,8,0, 0, 0,1,1,0, "R4");
    // R5: user accesses from both worlds
    step(1,1,1,0, 0,9,8,0, 32'h0, 1,1,1,0, "R5");
    step(1,0,0,0, 0,9,8,0, 0, 1,1,1,1, "R5");
    step(1,1,0,0, 0,9,8,0, 32'h2A, 0,1,1,0, "R5");
    step(1,0,1,1, 0,9,8,0, 0, 0,0,1,0, "R5");
    // R1: near-miss selectors do not touch the register
    step(1,1,1,1, 1,9,8,0, 32'h0, 1,1,1,0, "R1");
    step(1,1,1,1, 0,8,8,0, 32'h0, 1,1,1,0, "R1");
    step(1,1,1,1, 0,9,7,0, 32'h0, 1,1,1,0, "R1");
    step(1,1,1,1, 0,9,8,1, 32'h0, 1,1,1,0, "R1");
    step(0,1,1,1, 0,9,8,0, 32'h0, 1,1,1,0, "R1");
    step(1,0,1,0, 0,9,8,1, 0, 0,1,1,0, "R1");
    step(1,0,1,1, 0,9,8,0, 0, 0,1,1,0, "R1");
    // R6/R7/R8: every value, written in the same cycle as a policy access
    for (int val = 0; val < 64; val++) begin
      step(1,1,1,1, 0,9,8,0, 32'(val), val%2==1, 1, 1, val%3==0, "R8");
      for (int c = 0; c < 16; c++)
        step(0,0,0,0, 0,0,0,0, 0, c[3], c[2], c[1], c[0], "R8");
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule